// File: doc/BRIEF.md
# Per-Line Edge Interrupt Controller

This block turns transitions on a group of already-synchronized digital lines into one level interrupt request. Each line has a direction bit that picks rising or falling transitions. A transition in the chosen direction sets a sticky pending bit for that line. Pending bits are gated by a per-line enable, ORed together, gated by a global enable, and registered to drive the request.

Software reaches the block through a flat register port with separate write and read strobes and a one-cycle registered read. Five locations are decoded: pending status (write one to clear), line enable, direction, control (global enable in bit 0) and a read-only view of the sampled line levels. Rewriting the direction bits never loses a transition and never invents one. A transition in the same cycle as the rewrite is caught if it matches either the old direction or the new one.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset the pending, line enable, direction and control registers read 0, and `irq` is 0. Addresses: 0 = pending status, 1 = line enable, 2 = direction, 3 = control (bit 0 = global enable), 4 = line levels.
- R2: Line i's pending bit is set at the first clock edge after `line_in[i]` changes in the selected direction (direction bit 1 = rising, 0 = falling). A change in the other direction leaves the bit unchanged.
- R3: A pending bit stays set until a write to address 0 with a 1 in that bit position. Zero bits in that write leave their pending bits unchanged.
- R4: If a clear and a new qualifying transition hit the same bit in the same cycle, the bit is set afterwards.
- R5: Writing the direction register while the lines are steady sets no pending bit.
- R6: A transition in the same cycle as a direction write is captured if it matches the direction in force before the write or the direction being written.
- R7: `irq` is 1 exactly one clock edge after the pending register holds a bit that is also set in the line enable register while control bit 0 is 1. It is 0 one edge after that condition ends.
- R8: Address 4 reads the line levels sampled at the previous clock edge. Writes to address 4 or to undecoded addresses change no register, and undecoded addresses read 0.
- R9: `rd_data` shows the register selected by `rd_addr` at the previous clock edge.
- R10: Leaving reset with any static level on `line_in` sets no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | NLINES | Synchronized line levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | NLINES | Write data |
| rd_addr | input | 3 | Read address, data returned next cycle |
| rd_data | output | NLINES | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a transition that lands in the very cycle a direction write commits. The bench drives the line change and the write strobe at the same falling clock edge, so both are seen at one rising edge. It also arranges one line whose transition matches only the old direction and another whose transition matches only the new one. The same technique places a falling line beside a write-one-to-clear of its own bit, which shows that setting wins.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS   = 3'd0,
    A_LINE_EN  = 3'd1,
    A_POLARITY = 3'd2,
    A_CONTROL  = 3'd3,
    A_LEVEL    = 3'd4
  } reg_addr_e;

  localparam int unsigned CTRL_GEN_BIT = 0;
endpackage

// File: rtl/edge_irq_detect.sv
module edge_irq_detect #(
  parameter int unsigned NLINES = 24
) (
  input  logic              clk,
  input  logic [NLINES-1:0] line_in,
  input  logic [NLINES-1:0] pol_cur,
  input  logic              pol_wr,
  input  logic [NLINES-1:0] pol_new,
  output logic [NLINES-1:0] sample_q,
  output logic [NLINES-1:0] event_o
);
  // Sample register loads every cycle, reset included, so no edge is
  // seen when reset is released onto a static level.
  always_ff @(posedge clk) begin
    sample_q <= line_in;
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic rise, fall, hit_old, hit_new;
    always_comb begin
      rise    = line_in[i] & ~sample_q[i];
      fall    = ~line_in[i] & sample_q[i];
      hit_old = pol_cur[i] ? rise : fall;
      hit_new = pol_new[i] ? rise : fall;
      // During a direction write either setting qualifies the edge.
      event_o[i] = hit_old | (pol_wr & hit_new);
    end
  end
endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
  import edge_irq_pkg::*;
#(
  parameter int unsigned NLINES = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NLINES-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NLINES-1:0] pending,
  input  logic [NLINES-1:0] level,
  output logic [NLINES-1:0] line_en_q,
  output logic [NLINES-1:0] pol_q,
  output logic              gen_q,
  output logic              pol_wr,
  output logic [NLINES-1:0] clr_mask,
  output logic [NLINES-1:0] rd_data_q
);
  always_comb begin
    pol_wr   = wr_en && (wr_addr == A_POLARITY);
    clr_mask = (wr_en && (wr_addr == A_STATUS)) ? wr_data : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_en_q <= '0;
      pol_q     <= '0;
      gen_q     <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_LINE_EN:  line_en_q <= wr_data;
        A_POLARITY: pol_q     <= wr_data;
        A_CONTROL:  gen_q     <= wr_data[CTRL_GEN_BIT];
        default:    ;
      endcase
    end
  end

  logic [NLINES-1:0] rd_mux;
  always_comb begin
    case (rd_addr)
      A_STATUS:   rd_mux = pending;
      A_LINE_EN:  rd_mux = line_en_q;
      A_POLARITY: rd_mux = pol_q;
      A_CONTROL:  rd_mux = {{(NLINES-1){1'b0}}, gen_q};
      A_LEVEL:    rd_mux = level;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_q <= '0;
    else     rd_data_q <= rd_mux;
  end
endmodule

// File: rtl/edge_irq_pending.sv
module edge_irq_pending #(
  parameter int unsigned NLINES = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] event_i,
  input  logic [NLINES-1:0] clr_mask,
  input  logic [NLINES-1:0] line_en,
  input  logic              gen,
  output logic [NLINES-1:0] pending_q,
  output logic              irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      // Set has priority over clear.
      pending_q <= (pending_q & ~clr_mask) | event_i;
      irq_q     <= gen & (|(pending_q & line_en));
    end
  end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int unsigned NLINES = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] line_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NLINES-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NLINES-1:0] rd_data,
  output logic              irq
);
  logic [NLINES-1:0] sample_q, event_v, pending_q, line_en_q, pol_q, clr_mask;
  logic              gen_q, pol_wr;

  edge_irq_detect #(.NLINES(NLINES)) u_detect (
    .clk(clk), .line_in(line_in), .pol_cur(pol_q), .pol_wr(pol_wr),
    .pol_new(wr_data), .sample_q(sample_q), .event_o(event_v)
  );

  edge_irq_regs #(.NLINES(NLINES)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .pending(pending_q), .level(sample_q),
    .line_en_q(line_en_q), .pol_q(pol_q), .gen_q(gen_q), .pol_wr(pol_wr),
    .clr_mask(clr_mask), .rd_data_q(rd_data)
  );

  edge_irq_pending #(.NLINES(NLINES)) u_pending (
    .clk(clk), .rst(rst), .event_i(event_v), .clr_mask(clr_mask),
    .line_en(line_en_q), .gen(gen_q), .pending_q(pending_q), .irq_q(irq)
  );
endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk #(
  parameter int unsigned NLINES = 24
) (
  input logic              clk,
  input logic              rst,
  input logic [NLINES-1:0] sample,
  input logic [NLINES-1:0] event_v,
  input logic [NLINES-1:0] pending,
  input logic [NLINES-1:0] line_en,
  input logic              gen,
  input logic              irq,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic [NLINES-1:0] wr_data,
  input logic [2:0]        rd_addr,
  input logic [NLINES-1:0] rd_data
);
  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pending == '0 && irq == 1'b0));

  assert_clear_only_by_write_R3: assert property (@(posedge clk) disable iff (rst)
    (($past(pending) & ~pending) &
     ~(($past(wr_en) && $past(wr_addr) == 3'd0) ? $past(wr_data) : '0)) == '0);

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(event_v) & ~pending) == '0);

  assert_no_phantom_R5: assert property (@(posedge clk) disable iff (rst)
    ((pending & ~$past(pending)) & ~(sample ^ $past(sample))) == '0);

  assert_irq_latency_R7: assert property (@(posedge clk) disable iff (rst)
    irq == ($past(gen) && (|($past(pending) & $past(line_en)))));

  assert_status_read_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == 3'd0) |-> rd_data == $past(pending));
endmodule

bind edge_irq_ctrl edge_irq_chk #(.NLINES(NLINES)) u_chk (
  .clk(clk), .rst(rst), .sample(sample_q), .event_v(event_v),
  .pending(pending_q), .line_en(line_en_q), .gen(gen_q), .irq(irq),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sim_edge_irq_ctrl.sv
`timescale 1ns/1ps
module sim_edge_irq_ctrl;
  localparam int N = 24;
  localparam logic [N-1:0] POL_CFG = 24'h00FF00;
  localparam int NV = 10;
  localparam logic [N-1:0] VEC [NV] = '{
    24'h000001, 24'h000000, 24'h00FF00, 24'h000000, 24'hFFFFFF,
    24'h0F0F0F, 24'hF0F0F0, 24'hAAAAAA, 24'h555555, 24'h000000
  };

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, irq;
  logic [N-1:0] line_in = '0, wr_data = '0, rd_data;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  edge_irq_ctrl #(.NLINES(N)) u0 (
    .clk(clk), .rst(rst), .line_in(line_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [N-1:0] d);
    rd_addr = a;
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  function automatic logic [N-1:0] expect_evt(logic [N-1:0] o, logic [N-1:0] n, logic [N-1:0] p);
    return ((n & ~o) & p) | ((~n & o) & ~p);
  endfunction

  logic [N-1:0] v, prev, exp;

  initial begin
    // R10 / R1: reset released onto a static non-zero level
    line_in = 24'h123456;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 irq", {23'd0, irq}, '0);
    rd(3'd0, v); check("R10 status", v, '0);
    rd(3'd1, v); check("R1 line_en", v, '0);
    rd(3'd2, v); check("R1 polarity", v, '0);
    rd(3'd3, v); check("R1 control", v, '0);
    rd(3'd4, v); check("R8 level", v, 24'h123456);

    // configure and settle
    line_in = '0;
    @(posedge clk); @(negedge clk);
    wr(3'd2, POL_CFG); wr(3'd1, '1); wr(3'd3, 24'h1); wr(3'd0, '1);
    @(posedge clk); @(negedge clk);

    // vector table: R2 edge direction, R7 request
    prev = '0;
    for (int k = 0; k < NV; k++) begin
      line_in = VEC[k];
      @(posedge clk); @(negedge clk);
      rd(3'd0, v);
      exp = expect_evt(prev, VEC[k], POL_CFG);
      check("R2 status vector", v, exp);
      check("R7 irq vector", {23'd0, irq}, {23'd0, |exp});
      wr(3'd0, '1);
      @(posedge clk); @(negedge clk);
      prev = VEC[k];
    end

    // R5: direction rewrite with steady lines
    line_in = 24'h00F0F0; @(posedge clk); @(negedge clk);
    wr(3'd0, '1);
    wr(3'd2, ~POL_CFG); wr(3'd2, POL_CFG);
    rd(3'd0, v); check("R5 no phantom", v, '0);

    // R6: edge coinciding with direction write
    line_in = 24'h000002; @(posedge clk); @(negedge clk);
    wr(3'd0, '1);
    line_in = 24'h000001; // bit0 rises (new dir), bit1 falls (old dir)
    wr(3'd2, POL_CFG | 24'h000003);
    rd(3'd0, v); check("R6 coincident edge", v, 24'h000003);

    // R4: clear and new edge on the same bit in the same cycle
    wr(3'd2, POL_CFG);
    line_in = 24'h000000; // bit0 falls, falling selected
    wr(3'd0, 24'h000003);
    rd(3'd0, v); check("R4 set beats clear", v, 24'h000001);

    // R3: zero write leaves bits, opposite edge does not clear
    wr(3'd0, '0);
    line_in = 24'h000001; @(posedge clk); @(negedge clk);
    rd(3'd0, v); check("R3 sticky", v, 24'h000001);

    // R7: line enable and global enable gating with latency
    wr(3'd1, 24'h000002);
    @(posedge clk); @(negedge clk);
    check("R7 masked line", {23'd0, irq}, '0);
    wr(3'd1, 24'h000001);
    check("R7 one edge after enable", {23'd0, irq}, '0);
    @(posedge clk); @(negedge clk);
    check("R7 enabled line", {23'd0, irq}, 24'h1);
    wr(3'd3, '0);
    check("R7 still high one edge", {23'd0, irq}, 24'h1);
    @(posedge clk); @(negedge clk);
    check("R7 global off", {23'd0, irq}, '0);

    // R8: writes to level and undecoded addresses ignored
    wr(3'd4, 24'hABCDEF); wr(3'd6, 24'hFFFFFF);
    rd(3'd4, v); check("R8 level read", v, 24'h000001);
    rd(3'd6, v); check("R8 undecoded read", v, '0);
    rd(3'd1, v); check("R8 line_en kept", v, 24'h000001);
    rd(3'd2, v); check("R8 polarity kept", v, POL_CFG);
    rd(3'd3, v); check("R8 control kept", v, '0);

    // R9: read latency
    rd_addr = 3'd2;
    #1; check("R9 before edge", rd_data, '0);
    @(posedge clk); @(negedge clk);
    check("R9 after edge", rd_data, POL_CFG);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule